// File: doc/BRIEF.md
# Flash Storage Program and Erase Unit

This block keeps a byte-wide flash storage image in on-chip RAM and carries out the program and erase requests that a serial-flash command sequencer hands it. A request is a one-cycle pulse. It carries an address, a data byte, an erase code and the current state of the write-enable latch. A program changes one byte in the same cycle. An erase then walks its range one byte per clock, and `busy` stays high while it does. A separate registered read port lets the sequencer stream bytes out.

Programming normally clears bits only: the stored byte becomes the old byte ANDed with the new one. A build-time option instead stores the new byte as given, so a flash command set can model an EEPROM. Two capability parameters state whether the part supports the small and the medium erase size. Asking for a size the part lacks raises an error pulse, but the erase still runs. Every erase length is a parameter and must be a power of two. The defaults are shrunk so the RAM stays small, and full-size parts set 4096 and 32768. An erase clears the aligned block that holds the request address.

Top module: `flash_pe_unit`

## Requirements
- R1: After reset is released, `busy` is high for exactly TOTAL = SECTOR_BYTES*SECTOR_COUNT cycles while the array is filled with 0xFF. During reset all error outputs are low.
- R2: With OVERWRITE=0, a program stores (old byte AND request byte), so bits can only go from 1 to 0.
- R3: With OVERWRITE=1, a program stores the request byte unchanged, which can turn 0 bits back into 1.
- R4: A program made while `wr_en` is low pulses `err_prot` for one cycle, and the byte is still written.
- R5: Erase code 0x20 sets to 0xFF the SMALL_ERASE_BYTES-aligned block holding `req_addr`, and leaves the bytes outside it untouched.
- R6: Erase code 0x52 sets to 0xFF the MID_ERASE_BYTES-aligned block holding `req_addr`.
- R7: Erase code 0xD8 sets to 0xFF the SECTOR_BYTES-aligned sector holding `req_addr`.
- R8: Erase code 0xC7 sets the whole array to 0xFF.
- R9: An erase made while `wr_en` is low pulses `err_prot`, never raises `busy`, and leaves the array unchanged.
- R10: An erase whose size capability parameter is 0 pulses `err_size` and still erases its block. In the default build the 0x52 size is unsupported and the 0x20 size is supported.
- R11: An erase with any code other than 0x20, 0x52, 0xD8 or 0xC7 pulses `err_size` and changes nothing.
- R12: An accepted erase of L bytes holds `busy` high for exactly L cycles, starting the cycle after the request. A request made while `busy` is high pulses `err_busy` and has no effect.
- R13: `rd_data` shows the stored byte at `rd_addr` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the fill sequence |
| req_valid | input | 1 | One-cycle request strobe |
| req_prog | input | 1 | 1 = program one byte, 0 = erase |
| req_code | input | 8 | Erase size code |
| req_addr | input | AW | Byte address of the request |
| req_data | input | 8 | Byte to program |
| wr_en | input | 1 | Write-enable qualifier sampled with the request |
| rd_addr | input | AW | Read port address |
| rd_data | output | 8 | Byte at the read address, one cycle later |
| busy | output | 1 | Fill or erase in progress |
| err_prot | output | 1 | Pulse: request made with write enable clear |
| err_size | output | 1 | Pulse: erase size unknown or not supported |
| err_busy | output | 1 | Pulse: request rejected while busy |

## Verification
The assertions take for granted that every request field is a known value whenever `req_valid` is high, that addresses fall inside the array, and that the erase-length parameters are powers of two no larger than the array. The stimulus changes inputs only on the falling clock edge and holds `req_valid` high for a single cycle. It uses only in-range addresses, and it keeps to the default parameter set plus one copy built with the overwrite option. It sends one request while an erase is running, and places the blocks being erased so that neighbours on both sides are programmed beforehand.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        FPE_IDLE,
        FPE_FILL,
        FPE_ERASE
    } fpe_state_e;

    localparam logic [7:0] CODE_ERASE_SMALL  = 8'h20;
    localparam logic [7:0] CODE_ERASE_MID    = 8'h52;
    localparam logic [7:0] CODE_ERASE_SECTOR = 8'hD8;
    localparam logic [7:0] CODE_ERASE_ALL    = 8'hC7;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/flash_pe_decode.sv
module flash_pe_decode
    import flash_pe_pkg::*;
#(
    parameter int AW                = 11,
    parameter int TOTAL_BYTES       = 2048,
    parameter int SECTOR_BYTES      = 1024,
    parameter int SMALL_ERASE_BYTES = 256,
    parameter int MID_ERASE_BYTES   = 512,
    parameter bit CAN_SMALL_ERASE   = 1'b1,
    parameter bit CAN_MID_ERASE     = 1'b0
) (
    input  logic [7:0]    code,
    input  logic [AW-1:0] addr,
    output logic          known,
    output logic          cap_ok,
    output logic [AW-1:0] first,
    output logic [AW-1:0] last
);

    localparam logic [AW-1:0] SMALL_MASK  = AW'(SMALL_ERASE_BYTES - 1);
    localparam logic [AW-1:0] MID_MASK    = AW'(MID_ERASE_BYTES - 1);
    localparam logic [AW-1:0] SECTOR_MASK = AW'(SECTOR_BYTES - 1);
    localparam logic [AW-1:0] TOP_ADDR    = AW'(TOTAL_BYTES - 1);

    always_comb begin
        known  = 1'b1;
        cap_ok = 1'b1;
        first  = '0;
        last   = TOP_ADDR;
        unique case (code)
            CODE_ERASE_SMALL: begin
                cap_ok = CAN_SMALL_ERASE;
                first  = addr & ~SMALL_MASK;
                last   = addr | SMALL_MASK;
            end
            CODE_ERASE_MID: begin
                cap_ok = CAN_MID_ERASE;
                first  = addr & ~MID_MASK;
                last   = addr | MID_MASK;
            end
            CODE_ERASE_SECTOR: begin
                first = addr & ~SECTOR_MASK;
                last  = addr | SECTOR_MASK;
            end
            CODE_ERASE_ALL: begin
                first = '0;
                last  = TOP_ADDR;
            end
            default: begin
                known  = 1'b0;
                cap_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int AW        = 11,
    parameter int DEPTH     = 2048,
    parameter bit OVERWRITE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_fill,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];
    logic [7:0] prog_val;
    logic [7:0] store_val;
    logic [7:0] rd_data_d, rd_data_q;

    generate
        if (OVERWRITE) begin : g_direct
            assign prog_val = wr_data;
        end else begin : g_and_merge
            assign prog_val = mem[wr_addr] & wr_data;
        end
    endgenerate

    always_comb begin
        store_val = wr_fill ? BLANK_BYTE : prog_val;
        rd_data_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= store_val;
        end
        rd_data_q <= rd_data_d;
    end

    assign rd_data = rd_data_q;

    // R5
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/flash_pe_unit.sv
module flash_pe_unit
    import flash_pe_pkg::*;
#(
    parameter int SECTOR_BYTES      = 1024,
    parameter int SECTOR_COUNT      = 2,
    parameter int SMALL_ERASE_BYTES = 256,
    parameter int MID_ERASE_BYTES   = 512,
    parameter bit CAN_SMALL_ERASE   = 1'b1,
    parameter bit CAN_MID_ERASE     = 1'b0,
    parameter bit OVERWRITE         = 1'b0,
    localparam int TOTAL_BYTES      = SECTOR_BYTES * SECTOR_COUNT,
    localparam int AW               = $clog2(TOTAL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_prog,
    input  logic [7:0]    req_code,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          wr_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          err_prot,
    output logic          err_size,
    output logic          err_busy
);

    localparam logic [AW-1:0] TOP_ADDR = AW'(TOTAL_BYTES - 1);

    typedef struct packed {
        fpe_state_e    st;
        logic [AW-1:0] ptr;
        logic [AW-1:0] last;
        logic          e_prot;
        logic          e_size;
        logic          e_busy;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          dec_known, dec_cap;
    logic [AW-1:0] dec_first, dec_last;
    logic          arr_we, arr_fill;
    logic [AW-1:0] arr_addr;

    flash_pe_decode #(
        .AW               (AW),
        .TOTAL_BYTES      (TOTAL_BYTES),
        .SECTOR_BYTES     (SECTOR_BYTES),
        .SMALL_ERASE_BYTES(SMALL_ERASE_BYTES),
        .MID_ERASE_BYTES  (MID_ERASE_BYTES),
        .CAN_SMALL_ERASE  (CAN_SMALL_ERASE),
        .CAN_MID_ERASE    (CAN_MID_ERASE)
    ) i_decode (
        .code  (req_code),
        .addr  (req_addr),
        .known (dec_known),
        .cap_ok(dec_cap),
        .first (dec_first),
        .last  (dec_last)
    );

    flash_pe_array #(
        .AW       (AW),
        .DEPTH    (TOTAL_BYTES),
        .OVERWRITE(OVERWRITE)
    ) i_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (arr_we),
        .wr_fill(arr_fill),
        .wr_addr(arr_addr),
        .wr_data(req_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.e_prot = 1'b0;
        seq_d.e_size = 1'b0;
        seq_d.e_busy = 1'b0;
        arr_we       = 1'b0;
        arr_fill     = 1'b0;
        arr_addr     = seq_q.ptr;
        if (seq_q.st == FPE_IDLE) begin
            if (req_valid) begin
                seq_d.e_prot = !wr_en;
                if (req_prog) begin
                    arr_we   = 1'b1;
                    arr_addr = req_addr;
                end else begin
                    seq_d.e_size = !(dec_known && dec_cap);
                    if (dec_known && wr_en) begin
                        seq_d.st   = FPE_ERASE;
                        seq_d.ptr  = dec_first;
                        seq_d.last = dec_last;
                    end
                end
            end
        end else begin
            seq_d.e_busy = req_valid;
            arr_we       = 1'b1;
            arr_fill     = 1'b1;
            if (seq_q.ptr == seq_q.last) begin
                seq_d.st = FPE_IDLE;
            end else begin
                seq_d.ptr = seq_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st     <= FPE_FILL;
            seq_q.ptr    <= '0;
            seq_q.last   <= TOP_ADDR;
            seq_q.e_prot <= 1'b0;
            seq_q.e_size <= 1'b0;
            seq_q.e_busy <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != FPE_IDLE);
    assign err_prot = seq_q.e_prot;
    assign err_size = seq_q.e_size;
    assign err_busy = seq_q.e_busy;

    // R12
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> (err_busy && !err_prot && !err_size));

    // R4
    prot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !wr_en) |=> err_prot);

    // R9
    locked_erase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_prog && !wr_en) |=> !busy);

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && !req_prog && wr_en));

    // R5
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (seq_q.ptr <= seq_q.last));

endmodule

// File: tb/test_flash_pe_unit.sv
`timescale 1ns/1ps
module test_flash_pe_unit;

    localparam int SECT  = 1024;
    localparam int NSECT = 2;
    localparam int TOTAL = SECT * NSECT;
    localparam int SMALL = 256;
    localparam int MID   = 512;
    localparam int AW    = $clog2(TOTAL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_prog = 1'b0;
    logic [7:0]    req_code = 8'h00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          wr_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data, rd_data_ow;
    logic          busy, err_prot, err_size, err_busy;
    logic          busy_ow, err_prot_ow, err_size_ow, err_busy_ow;

    always #2 clk = ~clk;

    flash_pe_unit i_flash_pe_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
        .req_code(req_code), .req_addr(req_addr), .req_data(req_data),
        .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .err_prot(err_prot), .err_size(err_size), .err_busy(err_busy)
    );

    flash_pe_unit #(.OVERWRITE(1'b1)) i_flash_pe_unit_ow (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
        .req_code(req_code), .req_addr(req_addr), .req_data(req_data),
        .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data_ow), .busy(busy_ow),
        .err_prot(err_prot_ow), .err_size(err_size_ow), .err_busy(err_busy_ow)
    );

    typedef struct {
        string      tag;
        int         what;
        logic [7:0] exp;
        int         due;
    } item_t;

    item_t      sb_q[$];
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] mdl    [TOTAL];
    logic [7:0] mdl_ow [TOTAL];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] observe(int what);
        case (what)
            0: return rd_data;
            1: return rd_data_ow;
            2: return {7'd0, err_prot};
            3: return {7'd0, err_size};
            4: return {7'd0, err_busy};
            5: return {7'd0, busy};
            default: return {7'd0, busy_ow};
        endcase
    endfunction

    function automatic void check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    task automatic expect_at(string tag, int what, logic [7:0] exp, int due);
        item_t it;
        it.tag = tag; it.what = what; it.exp = exp; it.due = due;
        sb_q.push_back(it);
    endtask

    // monitor: pops every expectation whose cycle has come
    initial begin
        forever begin
            @(negedge clk);
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].due == cyc) begin
                    check(sb_q[i].tag, observe(sb_q[i].what), sb_q[i].exp);
                    sb_q.delete(i);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(string tag, int a);
        rd_addr = AW'(a);
        expect_at(tag, 0, mdl[a], cyc + 1);
        expect_at({tag, " ow"}, 1, mdl_ow[a], cyc + 1);
        tick();
    endtask

    task automatic prog(string tag, int a, logic [7:0] d, logic we);
        req_valid = 1'b1; req_prog = 1'b1; req_addr = AW'(a);
        req_data = d; wr_en = we;
        expect_at(tag, 2, {7'd0, !we}, cyc + 1);
        expect_at(tag, 5, 8'd0, cyc + 1);
        mdl[a]    = mdl[a] & d;
        mdl_ow[a] = d;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic erase(string tag, logic [7:0] code, int a, logic we);
        bit known, cap;
        int len, base;
        int c0;
        known = 1'b1; cap = 1'b1; len = 0;
        case (code)
            8'h20: begin len = SMALL; cap = 1'b1; end
            8'h52: begin len = MID;   cap = 1'b0; end
            8'hD8: len = SECT;
            8'hC7: len = TOTAL;
            default: begin known = 1'b0; cap = 1'b0; end
        endcase
        base = known ? (a / len) * len : 0;
        c0 = cyc;
        req_valid = 1'b1; req_prog = 1'b0; req_code = code;
        req_addr = AW'(a); wr_en = we;
        expect_at(tag, 3, {7'd0, !(known && cap)}, c0 + 1);
        expect_at(tag, 2, {7'd0, !we}, c0 + 1);
        expect_at(tag, 5, {7'd0, known && we}, c0 + 1);
        tick();
        req_valid = 1'b0;
        if (known && we) begin
            for (int i = base; i < base + len; i++) begin
                mdl[i] = 8'hFF;
                mdl_ow[i] = 8'hFF;
            end
            expect_at({tag, " busy last"}, 5, 8'd1, c0 + len);
            expect_at({tag, " busy end"}, 5, 8'd0, c0 + len + 1);
            repeat (len + 1) tick();
        end else begin
            tick();
        end
    endtask

    initial begin
        int cnt;
        for (int i = 0; i < TOTAL; i++) begin
            mdl[i] = 8'hFF;
            mdl_ow[i] = 8'hFF;
        end
        repeat (4) tick();
        // R1 reset state
        check("R1 reset busy", {7'd0, busy}, 8'd1);
        check("R1 reset err", {5'd0, err_prot, err_size, err_busy}, 8'd0);
        rst_n = 1'b1;
        cnt = 0;
        while (busy && cnt < TOTAL + 10) begin
            cnt++;
            tick();
        end
        check("R1 fill cycles", cnt[7:0], TOTAL[7:0]);
        check("R1 fill cycles hi", cnt[15:8], TOTAL[15:8]);
        rd("R1 blank", 0);
        rd("R1 blank", 777);
        rd("R13 blank top", TOTAL - 1);

        // R2 / R3: second program over a programmed byte
        prog("R2 prog", 16, 8'hA5, 1'b1);
        prog("R2 prog again", 16, 8'h3C, 1'b1);
        rd("R2 R3 merge", 16);
        // R4: locked program still writes
        prog("R4 locked prog", 17, 8'h0F, 1'b0);
        rd("R4 data", 17);
        tick();

        // R5: small erase, neighbours on both sides
        prog("R5 pre", 255, 8'h00, 1'b1);
        prog("R5 pre", 512, 8'h00, 1'b1);
        prog("R5 pre", 336, 8'h00, 1'b1);
        erase("R5 R12 small erase", 8'h20, 261, 1'b1);
        rd("R5 below", 255);
        rd("R5 inside", 336);
        rd("R5 above", 512);

        // R6 / R10: medium erase unsupported but proceeds
        prog("R6 pre", 1040, 8'h00, 1'b1);
        prog("R6 pre", 1536, 8'h00, 1'b1);
        erase("R6 R10 mid erase", 8'h52, 1279, 1'b1);
        rd("R6 inside", 1040);
        rd("R6 above", 1536);
        rd("R6 kept", 512);

        // R9: locked erase
        prog("R9 pre", 32, 8'h00, 1'b1);
        erase("R9 locked erase", 8'h20, 32, 1'b0);
        rd("R9 unchanged", 32);
        rd("R9 unchanged", 16);

        // R11: unknown code
        erase("R11 unknown code", 8'h99, 32, 1'b1);
        rd("R11 unchanged", 32);

        // R7: sector erase
        prog("R7 pre", 1023, 8'h00, 1'b1);
        prog("R7 pre", 2032, 8'h00, 1'b1);
        erase("R7 sector erase", 8'hD8, 2035, 1'b1);
        rd("R7 below", 1023);
        rd("R7 inside", 2032);
        rd("R7 inside", 1536);

        // R12: request during erase is rejected
        prog("R12 pre", 768, 8'h5A, 1'b1);
        begin
            int c0;
            c0 = cyc;
            req_valid = 1'b1; req_prog = 1'b0; req_code = 8'h20;
            req_addr = AW'(0); wr_en = 1'b1;
            tick();
            req_valid = 1'b0;
            for (int i = 0; i < SMALL; i++) begin
                mdl[i] = 8'hFF;
                mdl_ow[i] = 8'hFF;
            end
            tick();
            req_valid = 1'b1; req_prog = 1'b1; req_addr = AW'(768);
            req_data = 8'h00; wr_en = 1'b1;
            expect_at("R12 reject", 4, 8'd1, cyc + 1);
            expect_at("R12 reject no prot", 2, 8'd0, cyc + 1);
            tick();
            req_valid = 1'b0;
            expect_at("R12 busy last", 5, 8'd1, c0 + SMALL);
            expect_at("R12 busy end", 5, 8'd0, c0 + SMALL + 1);
            repeat (SMALL) tick();
        end
        rd("R12 ignored prog", 768);
        rd("R12 erased", 16);

        // R8: erase everything, read all back
        erase("R8 chip erase", 8'hC7, 100, 1'b1);
        for (int a = 0; a < TOTAL; a++) rd("R8 R13 readback", a);

        repeat (4) tick();
        finish_run();
    end

endmodule